// File: doc/BRIEF.md
# Bayer defective pixel corrector

This block sits in a raw-image pipeline and repairs pixels that an upstream stage has flagged as dead. Pixels arrive one per valid beat, 12 bits each, together with a frame-start marker, a line-start marker and a per-pixel defect flag. The block keeps four previous lines and a few horizontal taps, which gives it a 5x5 neighbourhood around a centre pixel that trails the input by two lines and two pixels. In a Bayer mosaic the nearest pixels of the same colour as the centre are two steps away in each direction. A flagged centre is replaced by the rounded mean of those four pixels. An unflagged centre leaves the block untouched.

The output uses the same stream format and has a fixed latency counted in valid beats. The block uses the frame-start marker of the next frame to tell that the previous frame has ended. The last two rows of a frame therefore leave the block while the first two rows of the following frame are coming in. Along the image edges, a same-colour neighbour that falls outside the frame is replaced by the neighbour on the opposite side.

Top module: `bayer_dpc`

## Requirements
- R1: While reset is held and after its release, `out_valid`, `out_sof` and `out_sol` are 0 and `out_pix` is 0 until the first pixel leaves the block.
- R2: Each input pixel is 12 bits and is accepted only on a cycle with `in_valid` high. A pixel that has `in_sof` high also counts as a line start even when `in_sol` is low. The line width W stays the same within and across frames and must not exceed `MAX_COLS`.
- R3: Valid beats are counted from 0 after reset. The result for the pixel accepted on beat k appears, with `out_valid` high, in the cycle right after beat k+2W+2 is accepted. No output appears before that.
- R4: If a pixel's defect flag was 0, its output value equals its input value.
- R5: A flagged pixel at row r and column c is output as (U+D+L+Rt+2)>>2. U, D, L and Rt are the raw input values at (r-2,c), (r+2,c), (r,c-2) and (r,c+2). A neighbour that is itself flagged is still used at its raw value. Full-scale inputs do not overflow, so four neighbours of 4095 give 4095.
- R6: A vertical neighbour outside the frame takes the value of the opposite vertical neighbour. A horizontal neighbour outside the frame takes the value of the opposite horizontal neighbour. If both are outside, the centre's own value is used.
- R7: `out_sol` is 1 on the first pixel of each output line. `out_sof` is 1 only on row 0, column 0 of each output frame. Both markers are 0 whenever `out_valid` is 0.
- R8: A cycle with `in_valid` low is followed by a cycle with `out_valid` low. No data is lost or shifted because of the gap.
- R9: The bottom two rows of a frame, which use the next frame's start to detect the lower edge, are output while the next frame is streaming in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_pix | input | 12 | Raw Bayer sample |
| in_defect | input | 1 | Pixel is flagged as dead |
| out_valid | output | 1 | Output pixel present this cycle |
| out_sof | output | 1 | First output pixel of a frame |
| out_sol | output | 1 | First output pixel of a line |
| out_pix | output | 12 | Corrected or passed-through sample |

## Verification
The hardest cycles are those in which edge replication and averaging act on the same flagged pixel. This happens at a corner, where both a vertical and a horizontal neighbour must be replaced before the sum is formed. It also happens in the bottom rows, where the lower edge is only known from the next frame's start marker. The bench places defects at all four corners and along each edge, and a second frame keeps the pixel values near full scale. It then compares every output pixel with a coordinate-based model, so a wrong choice of side or an overflowed sum shows up as a wrong value. Idle gaps are mixed into the middle frame to show that stalls neither drop pixels nor shift them.

// File: rtl/bayer_dpc.sv
module bayer_dpc #(
  parameter int PIX_W    = 12,
  parameter int MAX_COLS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_sol,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_defect,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_sol,
  output logic [PIX_W-1:0] out_pix
);
  localparam int CW   = $clog2(MAX_COLS);
  localparam int EW   = PIX_W + 5;
  localparam int B_DF = PIX_W;
  localparam int B_SL = PIX_W + 1;
  localparam int B_SF = PIX_W + 2;
  localparam int B_R0 = PIX_W + 3;
  localparam int B_LV = PIX_W + 4;

  logic [CW-1:0] col_q;
  logic          row0_q;

  wire           sol_eff  = in_sol | in_sof;
  wire           row0_now = in_sof | (row0_q & ~in_sol);
  wire [CW-1:0]  addr     = sol_eff ? '0 : col_q + CW'(1);
  wire [EW-1:0]  e0       = {1'b1, row0_now, in_sof, sol_eff, in_defect, in_pix};

  logic [EW-1:0]    lb0 [MAX_COLS];
  logic [EW-1:0]    lb1 [MAX_COLS];
  logic [PIX_W:0]   lb2 [MAX_COLS];
  logic [PIX_W-1:0] lb3 [MAX_COLS];

  wire [EW-1:0]    e1 = lb0[addr];
  wire [EW-1:0]    e2 = lb1[addr];
  wire [PIX_W:0]   e3 = lb2[addr];
  wire [PIX_W-1:0] p4 = lb3[addr];

  logic [PIX_W:0]   r0_d1, r0_d2;
  logic             r1_d1, r1_d2;
  logic [EW-1:0]    r2_d1, r2_d2;
  logic [PIX_W:0]   r2_d3;
  logic [PIX_W-1:0] r2_d4;
  logic             r3_d1, r3_d2;
  logic [PIX_W-1:0] r4_d1, r4_d2;

  wire [PIX_W-1:0] c_pix  = r2_d2[PIX_W-1:0];
  wire [PIX_W-1:0] up_raw = r4_d2;
  wire [PIX_W-1:0] dn_raw = r0_d2[PIX_W-1:0];
  wire [PIX_W-1:0] lf_raw = r2_d4;
  wire [PIX_W-1:0] rt_raw = e2[PIX_W-1:0];

  wire up_out = r2_d2[B_R0] | r3_d2;
  wire dn_out = r1_d2 | r0_d2[PIX_W];
  wire lf_out = r2_d2[B_SL] | r2_d3[PIX_W];
  wire rt_out = r2_d1[B_SL] | e2[B_SL];

  wire [PIX_W-1:0] up_v = !up_out ? up_raw : (!dn_out ? dn_raw : c_pix);
  wire [PIX_W-1:0] dn_v = !dn_out ? dn_raw : (!up_out ? up_raw : c_pix);
  wire [PIX_W-1:0] lf_v = !lf_out ? lf_raw : (!rt_out ? rt_raw : c_pix);
  wire [PIX_W-1:0] rt_v = !rt_out ? rt_raw : (!lf_out ? lf_raw : c_pix);

  wire [PIX_W+1:0] sum = {2'b00, up_v} + {2'b00, dn_v} + {2'b00, lf_v} + {2'b00, rt_v}
                         + (PIX_W+2)'(2);
  wire [PIX_W-1:0] fixed = r2_d2[B_DF] ? sum[PIX_W+1:2] : c_pix;
  wire             emit  = in_valid & r2_d2[B_LV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      row0_q    <= 1'b0;
      r0_d1     <= '0;
      r0_d2     <= '0;
      r1_d1     <= 1'b0;
      r1_d2     <= 1'b0;
      r2_d1     <= '0;
      r2_d2     <= '0;
      r2_d3     <= '0;
      r2_d4     <= '0;
      r3_d1     <= 1'b0;
      r3_d2     <= 1'b0;
      r4_d1     <= '0;
      r4_d2     <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
      out_pix   <= '0;
      for (int i = 0; i < MAX_COLS; i++) begin
        lb0[i] <= '0;
        lb1[i] <= '0;
      end
    end else begin
      out_valid <= emit;
      out_sof   <= emit & r2_d2[B_SF];
      out_sol   <= emit & r2_d2[B_SL];
      if (in_valid) begin
        col_q     <= addr;
        row0_q    <= row0_now;
        lb0[addr] <= e0;
        lb1[addr] <= e1;
        r0_d1     <= {row0_now, in_pix};
        r0_d2     <= r0_d1;
        r1_d1     <= e1[B_R0];
        r1_d2     <= r1_d1;
        r2_d1     <= e2;
        r2_d2     <= r2_d1;
        r2_d3     <= {r2_d2[B_SL], r2_d2[PIX_W-1:0]};
        r2_d4     <= r2_d3[PIX_W-1:0];
        r3_d1     <= e3[PIX_W];
        r3_d2     <= r3_d1;
        r4_d1     <= p4;
        r4_d2     <= r4_d1;
        if (r2_d2[B_LV]) out_pix <= fixed;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      lb2[addr] <= {e2[B_R0], e2[PIX_W-1:0]};
      lb3[addr] <= e3[PIX_W-1:0];
    end
  end

  a_r2_line_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sol_eff) |-> (col_q != CW'(MAX_COLS - 1)));

  a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r3_out_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r7_markers_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_sof && !out_sol));

  a_r7_sof_is_sol: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> out_sol);

  a_r5_avg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(r2_d2[B_DF])) |->
      ((out_pix <= $past(up_v)) || (out_pix <= $past(dn_v)) ||
       (out_pix <= $past(lf_v)) || (out_pix <= $past(rt_v))) &&
      ((out_pix >= $past(up_v)) || (out_pix >= $past(dn_v)) ||
       (out_pix >= $past(lf_v)) || (out_pix >= $past(rt_v))));
endmodule

// File: tb/sim_bayer_dpc.sv
module sim_bayer_dpc;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int H    = 6;
  localparam int LAT  = 2 * W + 2;
  localparam int NDEF = 12;
  localparam int DEFS [NDEF][3] = '{
    '{0, 2, 3}, '{0, 3, 4}, '{0, 0, 0}, '{0, 5, 7}, '{0, 1, 6}, '{0, 4, 1},
    '{0, 2, 5}, '{1, 2, 2}, '{1, 3, 3}, '{1, 2, 4}, '{1, 5, 0}, '{1, 0, 7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, in_defect = 1'b0;
  logic [11:0] in_pix = '0;
  logic out_valid, out_sof, out_sol;
  logic [11:0] out_pix;

  int checks = 0, fails = 0, beats = 0, outs = 0, first_beat = -1;
  bit last_idle = 1'b0;
  int got_pix [3][H][W];
  bit got_sof [3][H][W];
  bit got_sol [3][H][W];

  always #(CLK_PERIOD / 2) clk = ~clk;

  bayer_dpc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
    .in_pix(in_pix), .in_defect(in_defect), .out_valid(out_valid), .out_sof(out_sof),
    .out_sol(out_sol), .out_pix(out_pix)
  );

  function automatic int pixval(int f, int r, int c);
    if (f == 1) return 4095 - ((r * 5 + c * 3) % 4);
    return ((r * 37 + c * 113 + f * 59) * 29 + r * c * 7) % 4096;
  endfunction

  function automatic bit is_def(int f, int r, int c);
    for (int i = 0; i < NDEF; i++)
      if (DEFS[i][0] == f && DEFS[i][1] == r && DEFS[i][2] == c) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int expect_pix(int f, int r, int c);
    int u, d, l, rt;
    bit uo, dn, lo, ro;
    int own;
    own = pixval(f, r, c);
    if (!is_def(f, r, c)) return own;
    uo = (r < 2); dn = (r + 2 >= H); lo = (c < 2); ro = (c + 2 >= W);
    u  = !uo ? pixval(f, r - 2, c) : (!dn ? pixval(f, r + 2, c) : own);
    d  = !dn ? pixval(f, r + 2, c) : (!uo ? pixval(f, r - 2, c) : own);
    l  = !lo ? pixval(f, r, c - 2) : (!ro ? pixval(f, r, c + 2) : own);
    rt = !ro ? pixval(f, r, c + 2) : (!lo ? pixval(f, r, c - 2) : own);
    return (u + d + l + rt + 2) / 4;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample();
    int f, r, c;
    if (last_idle) begin
      chk(!out_valid && !out_sol && !out_sof, "R8 idle gap", int'(out_valid), 0);
    end
    if (out_valid) begin
      if (first_beat < 0) first_beat = beats - 1;
      f = outs / (H * W);
      r = (outs % (H * W)) / W;
      c = outs % W;
      if (f < 3) begin
        got_pix[f][r][c] = int'(out_pix);
        got_sof[f][r][c] = out_sof;
        got_sol[f][r][c] = out_sol;
      end
      outs++;
    end
  endtask

  task automatic step(bit v, bit sf, bit sl, int p, bit df);
    in_valid = v; in_sof = sf; in_sol = sl; in_pix = 12'(p); in_defect = df;
    @(posedge clk);
    #1;
    if (v) beats++;
    last_idle = !v;
    sample();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual %0d cycles expected fewer", 20000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid && !out_sof && !out_sol && out_pix == 0, "R1 in reset", int'(out_pix), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(!out_valid && out_pix == 0, "R1 after release", int'(out_valid), 0);

    for (int f = 0; f < 3; f++) begin
      for (int r = 0; r < ((f == 2) ? 3 : H); r++) begin
        for (int c = 0; c < W; c++) begin
          if (f == 1 && ((r * W + c) % 5 == 4)) step(1'b0, 1'b0, 1'b0, 0, 1'b0);
          step(1'b1, (r == 0 && c == 0), (c == 0) && !(f == 2 && r == 0),
               pixval(f, r, c), is_def(f, r, c));
        end
      end
    end
    repeat (4) step(1'b0, 1'b0, 1'b0, 0, 1'b0);

    chk(first_beat == LAT, "R3 first output beat", first_beat, LAT);
    chk(outs == 2 * H * W + W - 2, "R9 output count", outs, 2 * H * W + W - 2);

    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < H; r++) begin
        for (int c = 0; c < W; c++) begin
          if (!is_def(f, r, c))
            chk(got_pix[f][r][c] == expect_pix(f, r, c), "R4 pass-through",
                got_pix[f][r][c], expect_pix(f, r, c));
          else if (r < 2 || r >= H - 2 || c < 2 || c >= W - 2)
            chk(got_pix[f][r][c] == expect_pix(f, r, c), "R6 edge replace",
                got_pix[f][r][c], expect_pix(f, r, c));
          else
            chk(got_pix[f][r][c] == expect_pix(f, r, c), "R5 average",
                got_pix[f][r][c], expect_pix(f, r, c));
          chk(got_sol[f][r][c] == (c == 0), "R7 line marker", int'(got_sol[f][r][c]), int'(c == 0));
          chk(got_sof[f][r][c] == (r == 0 && c == 0), "R7 frame marker",
              int'(got_sof[f][r][c]), int'(r == 0 && c == 0));
        end
      end
    end

    chk(got_pix[1][3][3] == 4093, "R5 near full scale", got_pix[1][3][3], 4093);
    chk(got_pix[0][5][7] == expect_pix(0, 5, 7), "R9 bottom corner", got_pix[0][5][7], expect_pix(0, 5, 7));
    chk(got_sol[2][0][0] && got_sof[2][0][0], "R2 frame start counts as line start",
        int'(got_sol[2][0][0]), 1);
    for (int c = 0; c < W - 2; c++)
      chk(got_pix[2][0][c] == pixval(2, 0, c), "R4 third frame row 0", got_pix[2][0][c], pixval(2, 0, c));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule